// File: doc/BRIEF.md
# EDO DRAM Strobe-Sequence Cycle Decoder

This block models the device side of an extended-data-out DRAM, so that a memory controller can be checked against it. The four active-low strobes (row strobe, column strobe, write strobe and output strobe) are brought into the clock domain through two-flop synchronizers. The block then works out what kind of memory cycle the controller ran by looking at the order in which strobe edges arrive. It does not decode any command field. It holds a small storage array addressed by the low bits of the row and column addresses. It also keeps an internal refresh row counter and drives a data-valid flag that keeps read data on the pins after the column strobe rises.

The cycle kinds it recognises are:

- read
- early write
- late write
- read-modify-write
- refresh of the row on the address pins
- counter-based refresh, entered with the column strobe already low
- self-refresh

When each row-strobe cycle ends, a status pulse of one clock reports the kind of cycle and the row it used. A scoreboard can compare that report against the cycles the controller intended to run. The delay that selects self-refresh is a cycle-count parameter.

Top module: `edo_dram_model`

## Requirements
- R1: While reset is held and directly after it, `dout_en` and `cyc_valid` are 0 and `cyc_type` reads 0, the standby code.
- R2: The row address is latched when the row strobe falls with the column strobe high. The column address is latched when the column strobe falls with the write strobe high. The addressed word then appears on `dout` with `dout_en` high while the output strobe is low. The ending row-strobe rise reports `cyc_type` 1 (read).
- R3: If the write strobe is low when the column strobe falls, `din` is stored at the addressed word and `dout_en` stays 0 for the whole cycle. The cycle reports `cyc_type` 2 (early write).
- R4: The write strobe may fall after a column-strobe fall taken as a read, while the column strobe is still low. Then `din` overwrites the addressed word and the output turns off. The cycle reports `cyc_type` 4 (read-modify-write) if the output strobe was low and the old data was being driven. Otherwise it reports `cyc_type` 3 (late write).
- R5: After the column strobe rises, `dout` and `dout_en` keep the last read word while the row strobe and output strobe stay low and the write strobe stays high. `dout_en` drops when the output strobe goes high and returns when it goes low again. It also drops when the row and column strobes are both high.
- R6: Several column-strobe pulses inside one row-strobe low period each access a new column of the same row.
- R7: A row-strobe low period with no column-strobe fall refreshes the row on the address pins. It keeps `dout_en` at 0 and reports `cyc_type` 5 with `cyc_row` equal to that row address.
- R8: If the column strobe is already low when the row strobe falls, the cycle is a counter refresh and reports `cyc_type` 6. The address pins are ignored. `cyc_row` is the counter value, which is 0 after reset and rises by one for each such cycle. `dout_en` stays 0.
- R9: A counter refresh that holds both strobes low for more than `SELF_CYCLES` clocks becomes self-refresh. Self-refresh continues whatever the column strobe does, ends on the row-strobe rise, and reports `cyc_type` 7.
- R10: `cyc_valid` pulses for exactly one clock per row-strobe rise, with `cyc_type` and `cyc_row` valid during that clock.
- R11: With the row and column strobes both high, `dout_en` is 0 whatever the write strobe and output strobe do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| cas_n | input | 1 | Column strobe, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| oe_n | input | 1 | Output strobe, active low, asynchronous |
| addr | input | AW | Multiplexed row/column address |
| din | input | DW | Write data |
| dout | output | DW | Read data |
| dout_en | output | 1 | Output drive enable (1 = driven, 0 = high impedance) |
| cyc_valid | output | 1 | One-clock end-of-cycle status strobe |
| cyc_type | output | 3 | Decoded cycle code (0 standby, 1 read, 2 early write, 3 late write, 4 read-modify-write, 5 row refresh, 6 counter refresh, 7 self-refresh) |
| cyc_row | output | AW | Row used by the reported cycle |

## Verification
A wrong phase or a wrong cycle class shows up at the row-strobe rise that ends the cycle: `cyc_type` or `cyc_row` is wrong in the single clock that `cyc_valid` is high. That is two clocks after the synchronized rise. A lost or stale data-held flag shows sooner, two clocks after the strobe change that should have switched `dout_en`. A bad write is only seen on a later read of the same word. A refresh counter that drifts is seen on the next counter refresh.

// File: rtl/edo_pkg.sv
// Shared types for the EDO DRAM cycle decoder.
// Assumes: cycle codes are visible at the status port and must stay fixed.
package edo_pkg;

    typedef enum logic [2:0] {
        CYC_STANDBY = 3'd0,
        CYC_READ    = 3'd1,
        CYC_EWRITE  = 3'd2,
        CYC_LWRITE  = 3'd3,
        CYC_RMW     = 3'd4,
        CYC_RONLY   = 3'd5,
        CYC_CBR     = 3'd6,
        CYC_SELF    = 3'd7
    } cyc_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ROW,
        PH_CBR,
        PH_SELF
    } phase_e;

    localparam int STB_RAS = 0;
    localparam int STB_CAS = 1;
    localparam int STB_WE  = 2;
    localparam int STB_OE  = 3;

endpackage

// File: rtl/edo_strobe_sync.sv
// Two-flop synchronizer for a bundle of active-low strobes.
// Output lvl is the synchronized strobe, active high (1 = strobe asserted).
// Assumes: each strobe is held for at least two clocks so it is not missed.
module edo_strobe_sync #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_n,
    output logic [N-1:0] lvl
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic s1, s2;

        // Bring one strobe into the clock domain; reset reads as deasserted.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= ~pin_n[g];
                s2 <= s1;
            end
        end

        assign lvl[g] = s2;
    end

endmodule

// File: rtl/edo_refresh_ctr.sv
// Internal refresh row counter, used by counter-based refresh cycles.
// Assumes: inc is a single-clock pulse; the counter wraps at 2**W.
module edo_refresh_ctr #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] value
);

    // Advance after each use; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)   value <= '0;
        else if (inc) value <= value + 1'b1;
    end

endmodule

// File: rtl/edo_cell_array.sv
// Small storage array indexed by the low row and column address bits.
// Assumes: read is asynchronous; contents are not reset (like real cells).
module edo_cell_array #(
    parameter int RB = 3,
    parameter int CB = 3,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [RB-1:0] row,
    input  logic [CB-1:0] wr_col,
    input  logic [CB-1:0] rd_col,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);

    localparam int DEPTH = 1 << (RB + CB);

    logic [DW-1:0] cells [DEPTH];

    // Store one word on a write request.
    always_ff @(posedge clk) begin
        if (wr_en) cells[{row, wr_col}] <= wr_data;
    end

    assign rd_data = cells[{row, rd_col}];

endmodule

// File: rtl/edo_cycle_fsm.sv
// Cycle classifier: tracks the row-strobe phase, latches row and column,
// orders the strobe edges into a cycle class, issues array writes, holds
// EDO read data, and reports each finished cycle for one clock.
// Assumes: inputs are synchronized levels (1 = asserted); addr and din are
// held stable around the strobe edges they belong to.
module edo_cycle_fsm
    import edo_pkg::*;
#(
    parameter int AW          = 11,
    parameter int DW          = 4,
    parameter int RB          = 3,
    parameter int CB          = 3,
    parameter int SELF_CYCLES = 5000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ras_lvl,
    input  logic          cas_lvl,
    input  logic          we_lvl,
    input  logic          oe_lvl,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    input  logic [AW-1:0] ref_row,
    input  logic [DW-1:0] rd_data,
    output logic          ref_inc,
    output logic          mem_we,
    output logic [RB-1:0] mem_row,
    output logic [CB-1:0] wr_col,
    output logic [CB-1:0] rd_col,
    output logic [DW-1:0] mem_wdata,
    output logic [DW-1:0] dout,
    output logic          dout_en,
    output logic          cyc_valid,
    output cyc_e          cyc_type,
    output logic [AW-1:0] cyc_row
);

    localparam int SCW = $clog2(SELF_CYCLES + 1);

    phase_e        phase;
    cyc_e          cls;
    logic          ras_q, cas_q, we_q;
    logic [AW-1:0] row_lat;
    logic [CB-1:0] col_lat;
    logic          has_data;
    logic [SCW-1:0] self_cnt;

    logic ras_fall, ras_rise, cas_fall, we_fall;
    logic col_open, early_wr, late_wr;

    // Previous synchronized levels, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_q <= 1'b0;
            cas_q <= 1'b0;
            we_q  <= 1'b0;
        end else begin
            ras_q <= ras_lvl;
            cas_q <= cas_lvl;
            we_q  <= we_lvl;
        end
    end

    // Edge events and the write decisions derived from them.
    always_comb begin
        ras_fall = ras_lvl & ~ras_q;
        ras_rise = ~ras_lvl & ras_q;
        cas_fall = cas_lvl & ~cas_q;
        we_fall  = we_lvl & ~we_q;
        col_open = (phase == PH_ROW) & cas_fall & ~ras_rise;
        early_wr = col_open & we_lvl;
        late_wr  = (phase == PH_ROW) & we_fall & cas_lvl & ~cas_fall
                 & ~ras_rise & (cls == CYC_READ);
    end

    assign ref_inc   = (phase == PH_IDLE) & ras_fall & cas_lvl;
    assign mem_we    = early_wr | late_wr;
    assign mem_row   = row_lat[RB-1:0];
    assign wr_col    = early_wr ? addr[CB-1:0] : col_lat;
    assign rd_col    = addr[CB-1:0];
    assign mem_wdata = din;
    assign dout_en   = has_data & oe_lvl & ~we_lvl & (ras_lvl | cas_lvl);

    // Phase tracking, classification, EDO data hold and status report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            cls       <= CYC_STANDBY;
            row_lat   <= '0;
            col_lat   <= '0;
            has_data  <= 1'b0;
            dout      <= '0;
            self_cnt  <= '0;
            cyc_valid <= 1'b0;
            cyc_type  <= CYC_STANDBY;
            cyc_row   <= '0;
        end else begin
            cyc_valid <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (ras_fall && cas_lvl) begin
                        phase    <= PH_CBR;
                        cls      <= CYC_CBR;
                        row_lat  <= ref_row;
                        self_cnt <= '0;
                        has_data <= 1'b0;
                    end else if (ras_fall) begin
                        phase   <= PH_ROW;
                        cls     <= CYC_RONLY;
                        row_lat <= addr;
                    end else if (!ras_lvl && !cas_lvl) begin
                        has_data <= 1'b0;
                    end
                end
                PH_ROW: begin
                    if (ras_rise) begin
                        phase     <= PH_IDLE;
                        cyc_valid <= 1'b1;
                        cyc_type  <= cls;
                        cyc_row   <= row_lat;
                    end else if (col_open) begin
                        col_lat <= addr[CB-1:0];
                        if (we_lvl) begin
                            cls      <= CYC_EWRITE;
                            has_data <= 1'b0;
                        end else begin
                            cls      <= CYC_READ;
                            dout     <= rd_data;
                            has_data <= 1'b1;
                        end
                    end else if (late_wr) begin
                        cls      <= (has_data && oe_lvl) ? CYC_RMW : CYC_LWRITE;
                        has_data <= 1'b0;
                    end
                end
                PH_CBR: begin
                    if (ras_rise) begin
                        phase     <= PH_IDLE;
                        cyc_valid <= 1'b1;
                        cyc_type  <= CYC_CBR;
                        cyc_row   <= row_lat;
                    end else if (ras_lvl && cas_lvl) begin
                        if (self_cnt == SCW'(SELF_CYCLES - 1)) phase <= PH_SELF;
                        else self_cnt <= self_cnt + 1'b1;
                    end
                end
                default: begin
                    if (ras_rise) begin
                        phase     <= PH_IDLE;
                        cyc_valid <= 1'b1;
                        cyc_type  <= CYC_SELF;
                        cyc_row   <= row_lat;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/edo_dram_model.sv
// Top of the EDO DRAM device model: synchronizes the strobes, then
// classifies cycles, refreshes, stores data and reports each cycle.
// Assumes: strobe and address timing is legal apart from edge ordering;
// RB and CB do not exceed AW.
module edo_dram_model
    import edo_pkg::*;
#(
    parameter int AW          = 11,
    parameter int DW          = 4,
    parameter int RB          = 3,
    parameter int CB          = 3,
    parameter int SELF_CYCLES = 5000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_en,
    output logic          cyc_valid,
    output logic [2:0]    cyc_type,
    output logic [AW-1:0] cyc_row
);

    localparam int NSTB = 4;

    logic [NSTB-1:0] lvl;
    logic [AW-1:0]   ref_row;
    logic            ref_inc, mem_we;
    logic [RB-1:0]   mem_row;
    logic [CB-1:0]   wr_col, rd_col;
    logic [DW-1:0]   mem_wdata, rd_data;
    cyc_e            type_e;

    edo_strobe_sync #(.N(NSTB)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n ({oe_n, we_n, cas_n, ras_n}),
        .lvl   (lvl)
    );

    edo_refresh_ctr #(.W(AW)) u_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (ref_inc),
        .value (ref_row)
    );

    edo_cell_array #(.RB(RB), .CB(CB), .DW(DW)) u_cells (
        .clk     (clk),
        .wr_en   (mem_we),
        .row     (mem_row),
        .wr_col  (wr_col),
        .rd_col  (rd_col),
        .wr_data (mem_wdata),
        .rd_data (rd_data)
    );

    edo_cycle_fsm #(
        .AW(AW), .DW(DW), .RB(RB), .CB(CB), .SELF_CYCLES(SELF_CYCLES)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ras_lvl   (lvl[STB_RAS]),
        .cas_lvl   (lvl[STB_CAS]),
        .we_lvl    (lvl[STB_WE]),
        .oe_lvl    (lvl[STB_OE]),
        .addr      (addr),
        .din       (din),
        .ref_row   (ref_row),
        .rd_data   (rd_data),
        .ref_inc   (ref_inc),
        .mem_we    (mem_we),
        .mem_row   (mem_row),
        .wr_col    (wr_col),
        .rd_col    (rd_col),
        .mem_wdata (mem_wdata),
        .dout      (dout),
        .dout_en   (dout_en),
        .cyc_valid (cyc_valid),
        .cyc_type  (type_e),
        .cyc_row   (cyc_row)
    );

    assign cyc_type = type_e;

endmodule

// File: rtl/edo_dram_checker.sv
// Property checker for edo_dram_model, attached by bind below.
// Assumes: pins are deasserted during reset.
module edo_dram_checker
    import edo_pkg::*;
#(
    parameter int AW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ras_n,
    input logic          cas_n,
    input logic          we_n,
    input logic          oe_n,
    input logic          dout_en,
    input logic          cyc_valid,
    input logic [2:0]    cyc_type,
    input logic [AW-1:0] cyc_row,
    input logic [AW-1:0] ref_row
);

    AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n && cas_n && $past(ras_n) && $past(cas_n) && $past(ras_n, 2) && $past(cas_n, 2))
        |-> !dout_en); // R11

    AST_OE_HIGH_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n && $past(oe_n) && $past(oe_n, 2)) |-> !dout_en); // R5

    AST_WE_LOW_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && !$past(we_n) && !$past(we_n, 2)) |-> !dout_en); // R3

    AST_STATUS_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |=> !cyc_valid); // R10

    AST_CBR_COUNTER_ADVANCED: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_type == 3'(CYC_CBR)) |-> ref_row == AW'(cyc_row + 1'b1)); // R8

    AST_SELF_COUNTER_ADVANCED: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_type == 3'(CYC_SELF)) |-> ref_row == AW'(cyc_row + 1'b1)); // R9

endmodule

bind edo_dram_model edo_dram_checker #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .dout_en   (dout_en),
    .cyc_valid (cyc_valid),
    .cyc_type  (cyc_type),
    .cyc_row   (cyc_row),
    .ref_row   (ref_row)
);

// File: tb/tb_edo_dram_model.sv
// Bench: vector table walked by one loop, then directed refresh tests.
module tb_edo_dram_model;

    localparam int AW   = 11;
    localparam int DW   = 4;
    localparam int SELF = 64;
    localparam int NV   = 34;

    typedef struct packed {
        logic        ras, cas, we, oe;
        logic [10:0] a;
        logic [3:0]  d;
        logic        en;
        logic [3:0]  q;
        logic [2:0]  et;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b1,1'b1,1'b1,11'd0,4'h0,1'b0,4'h0,3'd0},
        '{1'b0,1'b1,1'b1,1'b1,11'd5,4'h0,1'b0,4'h0,3'd0},
        '{1'b0,1'b0,1'b0,1'b1,11'd2,4'hA,1'b0,4'h0,3'd0},
        '{1'b0,1'b1,1'b1,1'b1,11'd2,4'hA,1'b0,4'h0,3'd0},
        '{1'b0,1'b0,1'b0,1'b1,11'd3,4'h6,1'b0,4'h0,3'd0},
        '{1'b0,1'b1,1'b1,1'b1,11'd3,4'h6,1'b0,4'h0,3'd0},
        '{1'b1,1'b1,1'b1,1'b1,11'd0,4'h0,1'b0,4'h0,3'd2},
        '{1'b0,1'b1,1'b1,1'b1,11'd5,4'h0,1'b0,4'h0,3'd0},
        '{1'b0,1'b0,1'b1,1'b0,11'd2,4'h0,1'b1,4'hA,3'd0},
        '{1'b0,1'b1,1'b1,1'b0,11'd3,4'h0,1'b1,4'hA,3'd0},
        '{1'b0,1'b0,1'b1,1'b0,11'd3,4'h0,1'b1,4'h6,3'd0},
        '{1'b0,1'b0,1'b1,1'b1,11'd3,4'h0,1'b0,4'h0,3'd0},
        '{1'b0,1'b0,1'b1,1'b0,11'd3,4'h0,1'b1,4'h6,3'd0},
        '{1'b0,1'b1,1'b1,1'b0,11'd3,4'h0,1'b1,4'h6,3'd0},
        '{1'b1,1'b1,1'b1,1'b0,11'd0,4'h0,1'b0,4'h0,3'd1},
        '{1'b1,1'b1,1'b0,1'b0,11'd0,4'h0,1'b0,4'h0,3'd0},
        '{1'b1,1'b1,1'b1,1'b0,11'd0,4'h0,1'b0,4'h0,3'd0},
        '{1'b0,1'b1,1'b1,1'b0,11'd5,4'h0,1'b0,4'h0,3'd0},
        '{1'b0,1'b0,1'b1,1'b0,11'd2,4'h0,1'b1,4'hA,3'd0},
        '{1'b0,1'b0,1'b0,1'b0,11'd2,4'h9,1'b0,4'h0,3'd0},
        '{1'b0,1'b1,1'b1,1'b1,11'd2,4'h9,1'b0,4'h0,3'd0},
        '{1'b1,1'b1,1'b1,1'b1,11'd0,4'h0,1'b0,4'h0,3'd4},
        '{1'b0,1'b1,1'b1,1'b1,11'd5,4'h0,1'b0,4'h0,3'd0},
        '{1'b0,1'b0,1'b1,1'b1,11'd3,4'h0,1'b0,4'h0,3'd0},
        '{1'b0,1'b0,1'b0,1'b1,11'd3,4'hC,1'b0,4'h0,3'd0},
        '{1'b0,1'b1,1'b1,1'b1,11'd3,4'hC,1'b0,4'h0,3'd0},
        '{1'b1,1'b1,1'b1,1'b1,11'd0,4'h0,1'b0,4'h0,3'd3},
        '{1'b0,1'b1,1'b1,1'b0,11'd5,4'h0,1'b0,4'h0,3'd0},
        '{1'b0,1'b0,1'b1,1'b0,11'd2,4'h0,1'b1,4'h9,3'd0},
        '{1'b0,1'b1,1'b1,1'b0,11'd2,4'h0,1'b1,4'h9,3'd0},
        '{1'b0,1'b0,1'b1,1'b0,11'd3,4'h0,1'b1,4'hC,3'd0},
        '{1'b1,1'b1,1'b1,1'b0,11'd0,4'h0,1'b0,4'h0,3'd1},
        '{1'b0,1'b1,1'b1,1'b0,11'd6,4'h0,1'b0,4'h0,3'd0},
        '{1'b1,1'b1,1'b1,1'b0,11'd0,4'h0,1'b0,4'h0,3'd5}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en, cyc_valid;
    logic [2:0]    cyc_type;
    logic [AW-1:0] cyc_row;

    int       checks = 0, failures = 0, exp_pulses = 0, mon_cnt = 0, dbl = 0;
    logic [2:0]    mon_type = '0;
    logic [AW-1:0] mon_row = '0;
    logic          prev_valid = 1'b0;
    bit            done = 1'b0;

    always #10 clk = ~clk;

    edo_dram_model #(.AW(AW), .DW(DW), .SELF_CYCLES(SELF)) dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .cyc_valid(cyc_valid), .cyc_type(cyc_type), .cyc_row(cyc_row)
    );

    // Capture each status pulse away from the active edge.
    always @(negedge clk) begin
        if (rst_n && cyc_valid) begin
            mon_type = cyc_type;
            mon_row  = cyc_row;
            mon_cnt++;
            if (prev_valid) dbl++;
        end
        prev_valid = cyc_valid;
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic r, c, w, o, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        if (r && !ras_n) exp_pulses++;
        ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = a; din = d;
        repeat (4) @(negedge clk);
    endtask

    function automatic string tag_of(input int i);
        if (i == 0)  return "R11";
        if (i <= 6)  return "R3";
        if (i <= 8)  return "R2";
        if (i == 9)  return "R5";
        if (i == 10) return "R6";
        if (i <= 14) return "R5";
        if (i <= 16) return "R11";
        if (i <= 26) return "R4";
        if (i <= 31) return "R6";
        return "R7";
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 dout_en in reset", 16'(dout_en), 16'h0);
        check("R1 cyc_valid in reset", 16'(cyc_valid), 16'h0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 cyc_type after reset", 16'(cyc_type), 16'h0);
        check("R1 dout_en after reset", 16'(dout_en), 16'h0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].ras, VEC[i].cas, VEC[i].we, VEC[i].oe, VEC[i].a, VEC[i].d);
            check({tag_of(i), " dout_en"}, 16'(dout_en), 16'(VEC[i].en));
            if (VEC[i].en) check({tag_of(i), " dout"}, 16'(dout), 16'(VEC[i].q));
            if (VEC[i].et != 3'd0) check({tag_of(i), " cyc_type"}, 16'(mon_type), 16'(VEC[i].et));
        end
        check("R7 row reported", 16'(mon_row), 16'd6);

        // R8: counter refresh, address pins ignored, counter from 0.
        drive(1'b1, 1'b0, 1'b1, 1'b0, 11'h7FF, 4'h0);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 11'h7FF, 4'h0);
        repeat (10) @(negedge clk);
        check("R8 dout_en in refresh", 16'(dout_en), 16'h0);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 11'h123, 4'h0);
        check("R8 type first", 16'(mon_type), 16'd6);
        check("R8 row first", 16'(mon_row), 16'd0);
        drive(1'b1, 1'b0, 1'b1, 1'b1, 11'h055, 4'h0);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 11'h055, 4'h0);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 11'h055, 4'h0);
        check("R8 type second", 16'(mon_type), 16'd6);
        check("R8 row second", 16'(mon_row), 16'd1);

        // R9: long hold enters self-refresh; column strobe released midway.
        drive(1'b1, 1'b0, 1'b1, 1'b1, 11'h0, 4'h0);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 11'h0, 4'h0);
        repeat (SELF + 20) @(negedge clk);
        drive(1'b0, 1'b1, 1'b1, 1'b1, 11'h0, 4'h0);
        repeat (10) @(negedge clk);
        check("R9 dout_en in self-refresh", 16'(dout_en), 16'h0);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 11'h0, 4'h0);
        check("R9 type self", 16'(mon_type), 16'd7);
        check("R9 row self", 16'(mon_row), 16'd2);

        // R8: a short counter refresh after self-refresh continues the count.
        drive(1'b1, 1'b0, 1'b1, 1'b1, 11'h0, 4'h0);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 11'h0, 4'h0);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 11'h0, 4'h0);
        check("R8 type after self", 16'(mon_type), 16'd6);
        check("R8 row after self", 16'(mon_row), 16'd3);

        check("R10 one pulse per cycle", 16'(mon_cnt), 16'(exp_pulses));
        check("R10 pulse one clock wide", 16'(dbl), 16'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule